// File: doc/BRIEF.md
# Ring-oscillator entropy collector

This block sits between a 32-bit register bus and a single raw entropy line coming from a free-running ring oscillator. Software picks how many clocks separate two samples of that line, and how many bits one run gathers (64, 128, 192 or 256). It then starts a run and polls until the start flag drops. The gathered bits are then read from a window of eight 32-bit words. The block also drives the oscillator's enable and its two-bit speed select.

The control register takes masked writes. The upper half of each written word is a per-bit write enable for the lower half, so software can change one field without first reading the register. A separate reset-control register clears the control state and the collected data in one write. Register reads are combinational: `bus_rdata` follows `bus_addr` within the same cycle.

Top module: `trng_ctrl`

## Requirements
- R1: After reset the control register reads 0, the sample-period register reads 1000, all eight data words read 0, and `osc_en_o` is low.
- R2: A write to the control register at offset 0x400 updates control bit i (i in 0..5) only when write-data bit 16+i is set. Read-back bits 31:6 of the control register are always zero.
- R3: Control bit 1 (enable) drives `osc_en_o`, and control bits 3:2 drive `osc_speed_o`.
- R4: The sample-period register at offset 0x404 reads back the full 32-bit value written. A period of 0 behaves exactly like a period of 1.
- R5: Suppose a control write leaves enable at 1 and writes 1 into bit 0 (start) with its mask bit set. Bit 0 then reads 1 from that write edge on, and it reads 0 again N*P clock edges after the write edge. Here N = 64*(len+1), len is control bits 5:4, and P is the effective period.
- R6: Collected bit k (k = 0..N-1) is the entropy input sampled on the (k+1)*P-th edge after the start write. It lands in data word k/32 (offset 0x410 + 4*(k/32)) at bit k%32.
- R7: Starting a run clears every data word, so the words above the selected length read 0 after the run.
- R8: A start write that leaves enable at 0 does not set bit 0, and the data words do not change.
- R9: Writing 0xFFFF0000 to the control register during a run stops it at once. Bit 0 and `osc_en_o` drop, and the data words stay frozen afterwards.
- R10: A write with bit 0 set to the reset-control register at offset 0x004 clears the control register and all data words. That register itself reads 0.
- R11: Reads of any address other than 0x400, 0x404 and the word-aligned addresses 0x410..0x42C return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| entropy_i | input | 1 | Raw oscillator bit, already synchronised |
| osc_en_o | output | 1 | Oscillator enable |
| osc_speed_o | output | 2 | Oscillator speed select |

## Verification
A register write takes effect on the edge that samples it. The bench therefore reads results back at the falling edge after that write, with no extra wait, because reads are combinational. For a run, the bench records the edge index of the start write. It counts falling edges until bit 0 reads 0 and expects exactly N*P. It rebuilds each word from its own per-edge record of the entropy input at edges E+(k+1)*P. Stop and ignore cases are judged by reading the words right after the stimulus and again many cycles later.

// File: rtl/trng_pkg.sv
package trng_pkg;
   localparam logic [11:0] OFS_RSTCTL = 12'h004;
   localparam logic [11:0] OFS_CTL    = 12'h400;
   localparam logic [11:0] OFS_PERIOD = 12'h404;
   localparam logic [11:0] OFS_DATA   = 12'h410;

   // field order matches the bit positions software writes
   typedef struct packed {
      logic [1:0] len;
      logic [1:0] speed;
      logic       en;
      logic       start;
   } ctl_t;

   localparam int CTL_W = 6;
endpackage

// File: rtl/trng_cfg_regs.sv
module trng_cfg_regs
   import trng_pkg::*;
#(
   parameter int          PERIOD_W   = 32,
   parameter logic [31:0] RST_PERIOD = 32'd1000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_ctl,
   input  logic                wr_period,
   input  logic                soft_clr,
   input  logic                done,
   input  logic [CTL_W-1:0]    ctl_val,
   input  logic [CTL_W-1:0]    ctl_mask,
   input  logic [PERIOD_W-1:0] period_wdata,
   output ctl_t                ctl_q,
   output logic [PERIOD_W-1:0] period_q,
   output logic                launch
);
   ctl_t base, merged;

   always_comb begin
      base       = ctl_q;
      if (done) base.start = 1'b0;
      merged     = ctl_t'((base & ~ctl_mask) | (ctl_val & ctl_mask));
      merged.start = merged.start & merged.en;
      launch     = wr_ctl && ctl_mask[0] && ctl_val[0] && merged.en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctl_q <= '0;
      else if (soft_clr) ctl_q <= '0;
      else if (wr_ctl)   ctl_q <= merged;
      else               ctl_q <= base;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         period_q <= PERIOD_W'(RST_PERIOD);
      else if (wr_period) period_q <= period_wdata;
   end
endmodule

// File: rtl/trng_sampler.sv
module trng_sampler #(
   parameter int NUM_WORDS = 8,
   parameter int PERIOD_W  = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    launch,
   input  logic                    run,
   input  logic [PERIOD_W-1:0]     period,
   input  logic [1:0]              len,
   input  logic                    entropy,
   output logic                    done,
   output logic [NUM_WORDS*32-1:0] data_flat
);
   localparam int IDX_W  = $clog2(NUM_WORDS * 32);
   localparam int WSEL_W = $clog2(NUM_WORDS);

   logic [PERIOD_W-1:0] cnt_q, period_eff;
   logic [IDX_W-1:0]    idx_q, idx_last;
   logic                tick;

   always_comb begin
      period_eff = (period == '0) ? PERIOD_W'(1) : period;
      idx_last   = {len, 6'h3F};
      tick       = run && !launch && !clr && (cnt_q == period_eff - PERIOD_W'(1));
      done       = tick && (idx_q == idx_last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         idx_q <= '0;
      end else if (clr || launch) begin
         cnt_q <= '0;
         idx_q <= '0;
      end else if (run) begin
         if (tick) begin
            cnt_q <= '0;
            idx_q <= idx_q + IDX_W'(1);
         end else begin
            cnt_q <= cnt_q + PERIOD_W'(1);
         end
      end
   end

   for (genvar gw = 0; gw < NUM_WORDS; gw++) begin : g_word
      logic [31:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (clr || launch)
            word_q <= '0;
         else if (tick && (idx_q[IDX_W-1:5] == WSEL_W'(gw)))
            word_q[idx_q[4:0]] <= entropy;
      end
      assign data_flat[gw*32 +: 32] = word_q;
   end
endmodule

// File: rtl/trng_ctrl.sv
module trng_ctrl
   import trng_pkg::*;
#(
   parameter int          NUM_WORDS  = 8,
   parameter int          ADDR_W     = 12,
   parameter int          PERIOD_W   = 32,
   parameter logic [31:0] RST_PERIOD = 32'd1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              entropy_i,
   output logic              osc_en_o,
   output logic [1:0]        osc_speed_o
);
   localparam int WSEL_W   = $clog2(NUM_WORDS);
   localparam int WIN_SIZE = 4 * NUM_WORDS;

   if (NUM_WORDS != 8) begin : g_bad_words
      $error("NUM_WORDS must be 8 to hold a 256-bit run");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x42C");
   end
   if (PERIOD_W < 1 || PERIOD_W > 32) begin : g_bad_period
      $error("PERIOD_W must be 1..32");
   end

   ctl_t                    ctl_q;
   logic [PERIOD_W-1:0]     period_q;
   logic [NUM_WORDS*32-1:0] data_flat;
   logic                    wr_ctl, wr_period, soft_clr, launch, done;
   logic [ADDR_W-1:0]       win_ofs;
   logic                    in_win;

   assign wr_ctl    = bus_we && (bus_addr == ADDR_W'(OFS_CTL));
   assign wr_period = bus_we && (bus_addr == ADDR_W'(OFS_PERIOD));
   assign soft_clr  = bus_we && (bus_addr == ADDR_W'(OFS_RSTCTL)) && bus_wdata[0];

   trng_cfg_regs #(.PERIOD_W(PERIOD_W), .RST_PERIOD(RST_PERIOD)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ctl      (wr_ctl),
      .wr_period   (wr_period),
      .soft_clr    (soft_clr),
      .done        (done),
      .ctl_val     (bus_wdata[CTL_W-1:0]),
      .ctl_mask    (bus_wdata[16 +: CTL_W]),
      .period_wdata(bus_wdata[PERIOD_W-1:0]),
      .ctl_q       (ctl_q),
      .period_q    (period_q),
      .launch      (launch)
   );

   trng_sampler #(.NUM_WORDS(NUM_WORDS), .PERIOD_W(PERIOD_W)) u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_clr),
      .launch   (launch),
      .run      (ctl_q.start),
      .period   (period_q),
      .len      (ctl_q.len),
      .entropy  (entropy_i),
      .done     (done),
      .data_flat(data_flat)
   );

   assign osc_en_o    = ctl_q.en;
   assign osc_speed_o = ctl_q.speed;

   always_comb begin
      win_ofs   = bus_addr - ADDR_W'(OFS_DATA);
      in_win    = (bus_addr >= ADDR_W'(OFS_DATA)) && (win_ofs < ADDR_W'(WIN_SIZE))
                  && (bus_addr[1:0] == 2'b00);
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CTL))
         bus_rdata = 32'(ctl_q);
      else if (bus_addr == ADDR_W'(OFS_PERIOD))
         bus_rdata = 32'(period_q);
      else if (in_win)
         bus_rdata = data_flat[win_ofs[2 +: WSEL_W]*32 +: 32];
   end
endmodule

// File: rtl/trng_ctrl_chk.sv
module trng_ctrl_chk #(
   parameter int NUM_WORDS = 8,
   parameter int ADDR_W    = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic                    launch,
   input logic                    clr,
   input logic                    done,
   input logic                    wr_ctl,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [31:0]             bus_rdata,
   input logic [NUM_WORDS*32-1:0] data_flat
);
   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !launch && !clr) |=> $stable(data_flat)); // R9

   AST_DONE_DROPS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wr_ctl && !clr) |=> !start); // R5

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (data_flat == '0)); // R10

   AST_LAUNCH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !clr) |=> (data_flat[NUM_WORDS*32-1:1] == '0)); // R7

   AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(12'h400)) |-> (bus_rdata[31:6] == 26'd0)); // R2
endmodule

bind trng_ctrl trng_ctrl_chk #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (ctl_q.start),
   .launch   (launch),
   .clr      (soft_clr),
   .done     (done),
   .wr_ctl   (wr_ctl),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .data_flat(data_flat)
);

// File: tb/trng_ctrl_bench.sv
module trng_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        entropy;
   logic        osc_en;
   logic [1:0]  osc_speed;

   int          errors = 0;
   int          checks = 0;
   int unsigned cyc = 0;
   logic        hist [4096];
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   trng_ctrl u_trng_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .entropy_i(entropy),
      .osc_en_o(osc_en), .osc_speed_o(osc_speed)
   );

   assign entropy = lfsr[0];
   always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   always @(posedge clk) begin
      hist[cyc % 4096] <= entropy;
      cyc <= cyc + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, output int unsigned e);
      @(negedge clk);
      e = cyc;
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic snap(output logic [31:0] s [8]);
      for (int w = 0; w < 8; w++) rd(12'h410 + 12'(4 * w), s[w]);
   endtask

   task automatic do_run(input int p, input int len);
      int unsigned e, n, pe, c;
      logic [31:0] d, expw;
      wr(12'h404, 32'(p), e);
      wr(12'h400, 32'h0033_0003 | (32'(len) << 4), e);
      pe = (p == 0) ? 1 : p;
      n  = 64 * (len + 1);
      c  = 0;
      rd(12'h400, d);
      while (d[0] && c < 5000) begin
         @(negedge clk);
         c++;
         rd(12'h400, d);
      end
      chk($sformatf("R5 done edges p=%0d len=%0d", p, len), c, n * pe);
      for (int w = 0; w < 8; w++) begin
         expw = '0;
         for (int b = 0; b < 32; b++)
            if (w * 32 + b < int'(n)) expw[b] = hist[(e + (w * 32 + b + 1) * pe) % 4096];
         rd(12'h410 + 12'(4 * w), d);
         chk($sformatf("%s word%0d p=%0d len=%0d", (w * 32 < int'(n)) ? "R6" : "R7", w, p, len),
             d, expw);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R5 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int unsigned e;
      logic [31:0] d;
      logic [31:0] s0 [8];
      logic [31:0] s1 [8];
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(12'h400, d); chk("R1 ctl", d, 32'h0);
      rd(12'h404, d); chk("R1 period", d, 32'd1000);
      snap(s0);
      for (int w = 0; w < 8; w++) chk("R1 data", s0[w], 32'h0);
      chk("R1 osc_en", 32'(osc_en), 32'h0);
      // R2 / R3 masked field writes
      wr(12'h400, 32'h003C_FFFE, e);
      rd(12'h400, d); chk("R2 speed+len only", d, 32'h3C);
      chk("R3 speed", 32'(osc_speed), 32'h3);
      wr(12'h400, 32'h0002_0002, e);
      rd(12'h400, d); chk("R2 enable only", d, 32'h3E);
      chk("R3 enable", 32'(osc_en), 32'h1);
      wr(12'h400, 32'h0030_0000, e);
      rd(12'h400, d); chk("R2 clear len", d, 32'h0E);
      wr(12'h400, 32'hFFC0_FFC0, e);
      rd(12'h400, d); chk("R2 upper bits ignored", d, 32'h0E);
      // R4 period register
      wr(12'h404, 32'hA5A5_1234, e);
      rd(12'h404, d); chk("R4 period readback", d, 32'hA5A5_1234);
      // R5 R6 R7 sweep over periods and lengths
      for (int p = 1; p <= 3; p++)
         for (int len = 0; len < 4; len++) do_run(p, len);
      do_run(0, 0);   // R4 zero period acts as one
      do_run(0, 1);
      // R8 start with enable low
      snap(s0);
      wr(12'h400, 32'h0002_0000, e);
      wr(12'h400, 32'h0001_0001, e);
      rd(12'h400, d); chk("R8 start stays low", 32'(d[0]), 32'h0);
      repeat (20) @(negedge clk);
      snap(s1);
      for (int w = 0; w < 8; w++) chk("R8 data unchanged", s1[w], s0[w]);
      // R9 stop during a run
      wr(12'h404, 32'd3, e);
      wr(12'h400, 32'h0033_0033, e);
      repeat (50) @(negedge clk);
      wr(12'h400, 32'hFFFF_0000, e);
      rd(12'h400, d); chk("R9 ctl cleared", d, 32'h0);
      chk("R9 osc_en low", 32'(osc_en), 32'h0);
      snap(s0);
      repeat (100) @(negedge clk);
      snap(s1);
      for (int w = 0; w < 8; w++) chk("R9 data frozen", s1[w], s0[w]);
      // R10 reset-control register
      wr(12'h400, 32'h003E_003E, e);
      wr(12'h004, 32'h0000_0001, e);
      rd(12'h400, d); chk("R10 ctl cleared", d, 32'h0);
      rd(12'h004, d); chk("R10 reads zero", d, 32'h0);
      snap(s1);
      for (int w = 0; w < 8; w++) chk("R10 data cleared", s1[w], 32'h0);
      // R11 unmapped reads; refill data first so the window is nonzero
      do_run(1, 3);
      rd(12'h000, d); chk("R11 addr 000", d, 32'h0);
      rd(12'h408, d); chk("R11 addr 408", d, 32'h0);
      rd(12'h430, d); chk("R11 addr 430", d, 32'h0);
      rd(12'h411, d); chk("R11 addr 411", d, 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule